// File: doc/BRIEF.md
# Compressed Stream Header Checker and Bit Aligner

This block is the front end of a hardware inflate engine. It takes the compressed stream as 32-bit words, from either a register-write path or a DMA path, picked by a configuration input. The first word holds the two-byte zlib header. That header is checked before anything reaches the decoder: a bad header latches an error and the stream is refused from then on. A good header opens the stream. Its two bytes are dropped, and every later word passes through a 16-entry FIFO into a 64-bit bit buffer.

The Huffman decoder sees a window of the next 16 stream bits, least significant bit first. Each cycle it reports how many bits it used, from 0 to 16. The buffer shifts out exactly that many bits and refills from the FIFO whenever fewer than 32 bits would be left. A byte-align request drops the bits up to the next byte boundary of the stream; the decoder uses it before the checksum trailer. The input words can be read as little-endian or big-endian.

Top module: `zstream_aligner`

## Requirements
- R1: The header is formed from stream byte 0 (CMF) and stream byte 1 (FLG). It is accepted only if all four of these hold: CMF[3:0] equals 8, CMF[7:4] is at most 7, FLG bit 5 is 0, and the 16-bit value {CMF,FLG} is a multiple of 31. When it is accepted, `hdrGood` rises in the cycle after the header word is taken.
- R2: A rejected header raises `hdrError` in the cycle after the word is taken. It is not pushed into the FIFO. Both ready outputs stay low and `winValid` stays low until reset.
- R3: With no bits consumed, the block accepts exactly 18 words after the header check begins: 2 words in the bit buffer and 16 in the FIFO. Ready then drops, and no word is lost.
- R4: Window bit k equals stream bit (p+k). Stream bit b is bit (b mod 8) of stream byte (b div 8), and p is the current position. The first position is 16, so header bits never appear in the window.
- R5: A consume of n bits (1 to 16) accepted while `winValid` is high moves the position forward by exactly n.
- R6: With `cfgBigEndian` at 0, stream byte 0 of a word is bits [7:0]. With `cfgBigEndian` at 1, it is bits [31:24].
- R7: `winAvail` gives the number of buffered bits. `winValid` is high only when at least 16 bits are buffered, or when the last word has been taken, the FIFO is empty and bits remain. Window bits at and above `winAvail` read 0.
- R8: A byte-align request moves the position to the next multiple of 8. If the position is already byte-aligned, nothing changes. When the request comes with an accepted consume, the consume takes priority.
- R9: `cfgUseDma` selects the DMA path (1) or the register path (0). Valid on the path that is not selected is ignored, and that path's ready stays low.
- R10: Once a word marked last has been taken, no further word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgBigEndian | input | 1 | 1: byte 0 of a word is bits [31:24] |
| cfgUseDma | input | 1 | 1: take words from the DMA path |
| regWrValid | input | 1 | Register path word valid |
| regWrData | input | 32 | Register path word |
| regWrLast | input | 1 | Register path word is the last |
| regWrReady | output | 1 | Register path word accepted this cycle if valid |
| dmaValid | input | 1 | DMA path word valid |
| dmaData | input | 32 | DMA path word |
| dmaLast | input | 1 | DMA path word is the last |
| dmaReady | output | 1 | DMA path word accepted this cycle if valid |
| consumeEn | input | 1 | Decoder reports used bits |
| consumeBits | input | 5 | Number of bits used, 0 to 16 |
| alignReq | input | 1 | Drop bits up to the next byte boundary |
| winData | output | 16 | Next stream bits, LSB first |
| winValid | output | 1 | Window may be decoded |
| winAvail | output | 7 | Bits held in the bit buffer |
| hdrGood | output | 1 | Header accepted |
| hdrError | output | 1 | Header rejected |

## Verification
The consume-accounting assertion assumes the decoder never asks for more bits than `winAvail` shows. The stimulus keeps to this by limiting each consume to the bits left in its own model of the stream. The align assertion assumes align requests come only after the header has been accepted, and the bench issues them only in the middle of a stream. The bench also drives valid only on the selected path, except in the one test that checks the unselected path is ignored. It uses a fixed byte sequence with a known-good header, so every expected window is computed from stream positions alone.

// File: rtl/zsa_pkg.sv
package zsa_pkg;

  localparam int WORD_BITS = 32;

  // strobes from control to the bit datapath
  typedef struct packed {
    logic armSkip;    // first word carries the two header bytes
    logic inputDone;  // last word has entered the FIFO
  } zsaCtl_t;

  function automatic logic [WORD_BITS-1:0] orderBytes(input logic [WORD_BITS-1:0] w,
                                                      input logic bigEnd);
    return bigEnd ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
  endfunction

  function automatic logic headerOk(input logic [7:0] cmf, input logic [7:0] flg);
    logic [15:0] both;
    both = {cmf, flg};
    return (cmf[3:0] == 4'd8) && (cmf[7:4] <= 4'd7) && !flg[5] &&
           ((both % 16'd31) == 16'd0);
  endfunction

endpackage

// File: rtl/zsa_fifo.sv
module zsa_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [AW:0]      count;

  assign empty = (count == '0);
  assign full  = (count == (AW+1)'(DEPTH));
  assign head  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push && !full) wrPtr <= (wrPtr == AW'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (pop && !empty) rdPtr <= (rdPtr == AW'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      count <= count + (AW+1)'(push && !full) - (AW+1)'(pop && !empty);
    end
  end
endmodule

// File: rtl/zsa_ctrl.sv
module zsa_ctrl
  import zsa_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 srcValid,
  input  logic                 srcLast,
  input  logic [WORD_BITS-1:0] srcWord,
  input  logic                 fifoFull,
  output logic                 srcReady,
  output logic                 fifoPush,
  output zsaCtl_t              ctl,
  output logic                 hdrGood,
  output logic                 hdrError
);
  typedef enum logic [1:0] {ST_HDR, ST_RUN, ST_ERR} state_t;

  state_t state;
  logic   endSeen;
  logic   hdrPass;
  logic   taken;

  always_comb begin
    hdrPass  = headerOk(srcWord[7:0], srcWord[15:8]);
    srcReady = (state == ST_HDR) || (state == ST_RUN && !fifoFull && !endSeen);
    taken    = srcValid && srcReady && (state == ST_RUN || hdrPass);
    fifoPush = taken;
    ctl.armSkip   = (state == ST_HDR) && srcValid && hdrPass;
    ctl.inputDone = endSeen;
    hdrGood  = (state == ST_RUN);
    hdrError = (state == ST_ERR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_HDR;
      endSeen <= 1'b0;
    end else begin
      if (state == ST_HDR && srcValid) state <= hdrPass ? ST_RUN : ST_ERR;
      if (taken && srcLast) endSeen <= 1'b1;
    end
  end
endmodule

// File: rtl/zsa_datapath.sv
module zsa_datapath
  import zsa_pkg::*;
#(
  parameter int BUF_BITS = 64,
  parameter int WIN_BITS = 16,
  localparam int CW = $clog2(BUF_BITS + 1),
  localparam int NW = $clog2(WIN_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  zsaCtl_t              ctl,
  input  logic [WORD_BITS-1:0] fifoHead,
  input  logic                 fifoEmpty,
  input  logic                 consumeEn,
  input  logic [NW-1:0]        consumeBits,
  input  logic                 alignReq,
  output logic                 fifoPop,
  output logic [WIN_BITS-1:0]  winData,
  output logic                 winValid,
  output logic [CW-1:0]        winAvail
);
  logic [BUF_BITS-1:0]  bitBuf, keptBuf;
  logic [CW-1:0]        bitCnt, keptCnt, shiftN, loadLen;
  logic [WORD_BITS-1:0] loadWord;
  logic                 skipPend;
  logic                 drained;

  always_comb begin
    drained  = ctl.inputDone && fifoEmpty;
    winValid = (bitCnt >= CW'(WIN_BITS)) || (drained && bitCnt != '0);
    shiftN   = '0;
    if (consumeEn && winValid)
      shiftN = (CW'(consumeBits) > bitCnt) ? bitCnt : CW'(consumeBits);
    else if (alignReq)
      shiftN = {{(CW-3){1'b0}}, bitCnt[2:0]};
    keptBuf  = bitBuf >> shiftN;
    keptCnt  = bitCnt - shiftN;
    fifoPop  = !fifoEmpty && (keptCnt < CW'(WORD_BITS));
    loadWord = skipPend ? {16'h0, fifoHead[31:16]} : fifoHead;
    loadLen  = skipPend ? CW'(16) : CW'(WORD_BITS);
  end

  assign winData  = bitBuf[WIN_BITS-1:0];
  assign winAvail = bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitBuf   <= '0;
      bitCnt   <= '0;
      skipPend <= 1'b0;
    end else begin
      if (fifoPop) begin
        bitBuf <= keptBuf | (BUF_BITS'(loadWord) << keptCnt);
        bitCnt <= keptCnt + loadLen;
      end else begin
        bitBuf <= keptBuf;
        bitCnt <= keptCnt;
      end
      if (ctl.armSkip)  skipPend <= 1'b1;
      else if (fifoPop) skipPend <= 1'b0;
    end
  end
endmodule

// File: rtl/zstream_aligner.sv
module zstream_aligner
  import zsa_pkg::*;
#(
  parameter int WIN_BITS   = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int BUF_BITS   = 64,
  localparam int CW = $clog2(BUF_BITS + 1),
  localparam int NW = $clog2(WIN_BITS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgBigEndian,
  input  logic                cfgUseDma,
  input  logic                regWrValid,
  input  logic [31:0]         regWrData,
  input  logic                regWrLast,
  output logic                regWrReady,
  input  logic                dmaValid,
  input  logic [31:0]         dmaData,
  input  logic                dmaLast,
  output logic                dmaReady,
  input  logic                consumeEn,
  input  logic [NW-1:0]       consumeBits,
  input  logic                alignReq,
  output logic [WIN_BITS-1:0] winData,
  output logic                winValid,
  output logic [CW-1:0]       winAvail,
  output logic                hdrGood,
  output logic                hdrError
);
  logic                 srcValid, srcLast, srcReady;
  logic [WORD_BITS-1:0] srcWord, fifoHead;
  logic                 fifoPush, fifoPop, fifoEmpty, fifoFull;
  zsaCtl_t              ctl;
  logic                 endSeen;

  assign srcValid   = cfgUseDma ? dmaValid : regWrValid;
  assign srcLast    = cfgUseDma ? dmaLast  : regWrLast;
  assign srcWord    = orderBytes(cfgUseDma ? dmaData : regWrData, cfgBigEndian);
  assign regWrReady = !cfgUseDma && srcReady;
  assign dmaReady   = cfgUseDma && srcReady;
  assign endSeen    = ctl.inputDone;

  zsa_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .srcValid(srcValid), .srcLast(srcLast),
    .srcWord(srcWord), .fifoFull(fifoFull), .srcReady(srcReady),
    .fifoPush(fifoPush), .ctl(ctl), .hdrGood(hdrGood), .hdrError(hdrError)
  );

  zsa_fifo #(.WIDTH(WORD_BITS), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rstN(rstN), .push(fifoPush), .pushData(srcWord),
    .pop(fifoPop), .head(fifoHead), .empty(fifoEmpty), .full(fifoFull)
  );

  zsa_datapath #(.BUF_BITS(BUF_BITS), .WIN_BITS(WIN_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .fifoHead(fifoHead),
    .fifoEmpty(fifoEmpty), .consumeEn(consumeEn), .consumeBits(consumeBits),
    .alignReq(alignReq), .fifoPop(fifoPop), .winData(winData),
    .winValid(winValid), .winAvail(winAvail)
  );
endmodule

// File: rtl/zsa_checker.sv
module zsa_checker #(
  parameter int WIN_BITS = 16,
  parameter int BUF_BITS = 64,
  localparam int CW = $clog2(BUF_BITS + 1),
  localparam int NW = $clog2(WIN_BITS + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          regWrReady,
  input logic          dmaReady,
  input logic          hdrGood,
  input logic          hdrError,
  input logic          winValid,
  input logic [CW-1:0] winAvail,
  input logic          consumeEn,
  input logic [NW-1:0] consumeBits,
  input logic          alignReq,
  input logic          endSeen,
  input logic          fifoEmpty
);
  logic [CW-1:0] expectKeep;
  assign expectKeep = winAvail - CW'(consumeBits);

  AST_HDR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(hdrGood && hdrError));                                              // R1
  AST_ERR_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    hdrError |-> (!regWrReady && !dmaReady && !winValid));                // R2
  AST_BUF_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    winAvail <= CW'(BUF_BITS));                                           // R3
  AST_CONSUME_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (winValid && consumeEn && CW'(consumeBits) <= winAvail) |=>
      (winAvail == $past(expectKeep)) || (32'(winAvail) == 32'($past(expectKeep)) + 32)); // R5
  AST_VALID_DEPTH: assert property (@(posedge clk) disable iff (!rstN)
    (winValid && !(endSeen && fifoEmpty)) |-> winAvail >= CW'(WIN_BITS)); // R7
  AST_ALIGN_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    (hdrGood && alignReq && !(consumeEn && winValid)) |=> winAvail[2:0] == 3'd0); // R8
  AST_ONE_PATH: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrReady && dmaReady));                                           // R9
endmodule

bind zstream_aligner zsa_checker #(.WIN_BITS(WIN_BITS), .BUF_BITS(BUF_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .regWrReady(regWrReady), .dmaReady(dmaReady),
  .hdrGood(hdrGood), .hdrError(hdrError), .winValid(winValid),
  .winAvail(winAvail), .consumeEn(consumeEn), .consumeBits(consumeBits),
  .alignReq(alignReq), .endSeen(endSeen), .fifoEmpty(fifoEmpty)
);

// File: tb/tb_zstream_aligner.sv
`timescale 1ns/1ps
module tb_zstream_aligner;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgBigEndian, cfgUseDma;
  logic        regWrValid, regWrLast, dmaValid, dmaLast;
  logic [31:0] regWrData, dmaData;
  logic        regWrReady, dmaReady;
  logic        consumeEn, alignReq;
  logic [4:0]  consumeBits;
  logic [15:0] winData;
  logic        winValid;
  logic [6:0]  winAvail;
  logic        hdrGood, hdrError;

  int nChecks = 0;
  int nErr = 0;
  int pos;
  logic [7:0] sb [128];

  always #2 clk = ~clk;

  zstream_aligner dut (
    .clk(clk), .rstN(rstN), .cfgBigEndian(cfgBigEndian), .cfgUseDma(cfgUseDma),
    .regWrValid(regWrValid), .regWrData(regWrData), .regWrLast(regWrLast),
    .regWrReady(regWrReady), .dmaValid(dmaValid), .dmaData(dmaData),
    .dmaLast(dmaLast), .dmaReady(dmaReady), .consumeEn(consumeEn),
    .consumeBits(consumeBits), .alignReq(alignReq), .winData(winData),
    .winValid(winValid), .winAvail(winAvail), .hdrGood(hdrGood), .hdrError(hdrError)
  );

  // {CMF, FLG, accepted}
  localparam logic [16:0] HDR_VEC [7] = '{
    {8'h78, 8'h9C, 1'b1},  // common valid header
    {8'h78, 8'hDA, 1'b1},  // valid, other level
    {8'h08, 8'h1D, 1'b1},  // smallest window size
    {8'h78, 8'h9D, 1'b0},  // check value not multiple of 31
    {8'h79, 8'h18, 1'b0},  // method 9
    {8'h88, 8'h1C, 1'b0},  // window field 8
    {8'h78, 8'h20, 1'b0}   // preset dictionary flag
  };

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wordOf(input int i, input logic big);
    if (big) return {sb[4*i], sb[4*i+1], sb[4*i+2], sb[4*i+3]};
    return {sb[4*i+3], sb[4*i+2], sb[4*i+1], sb[4*i]};
  endfunction

  function automatic logic [15:0] expWin(input int p, input int total);
    logic [15:0] w;
    for (int k = 0; k < 16; k++) begin
      int b = p + k;
      w[k] = (b < total) ? sb[b >> 3][b & 7] : 1'b0;
    end
    return w;
  endfunction

  task automatic doReset();
    rstN = 1'b0;
    regWrValid = 0; regWrLast = 0; regWrData = '0;
    dmaValid = 0; dmaLast = 0; dmaData = '0;
    consumeEn = 0; consumeBits = '0; alignReq = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic pushWord(input logic [31:0] d, input logic last);
    if (cfgUseDma) begin dmaValid = 1; dmaData = d; dmaLast = last; end
    else begin regWrValid = 1; regWrData = d; regWrLast = last; end
    while (!(cfgUseDma ? dmaReady : regWrReady)) @(negedge clk);
    @(negedge clk);
    regWrValid = 0; dmaValid = 0; regWrLast = 0; dmaLast = 0;
  endtask

  task automatic consumeN(input int n);
    consumeEn = 1; consumeBits = 5'(n);
    @(negedge clk);
    consumeEn = 0;
    pos += n;
  endtask

  task automatic runConsume(input int total, input string tag);
    int step = 0;
    while (pos < total) begin
      int rem, n;
      while (!winValid) @(negedge clk);
      rem = total - pos;
      n = 1 + ((step * 7) % 16);
      if (n > rem) n = rem;
      check(winData == expWin(pos, total), tag, 32'(winData), 32'(expWin(pos, total)));
      if (rem < 16)   // R7 tail: drained buffer still valid, count exact
        check(winValid && winAvail == 7'(rem), "R7 tail count", 32'(winAvail), 32'(rem));
      consumeN(n);
      step++;
    end
    check(!winValid && winAvail == 0, "R7 empty after stream", 32'(winAvail), 0);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 128; i++) sb[i] = 8'((i * 37 + 11) & 255);
    sb[0] = 8'h78; sb[1] = 8'h9C;
    cfgBigEndian = 0; cfgUseDma = 0;

    // reset state
    doReset();
    check(!hdrGood && !hdrError, "R1 reset flags", {hdrGood, hdrError}, 0);
    check(!winValid && winAvail == 0, "R7 reset window", 32'(winAvail), 0);
    check(regWrReady && !dmaReady, "R9 reset ready", {regWrReady, dmaReady}, 2);

    // header vector table: R1 and R2
    for (int v = 0; v < 7; v++) begin
      logic ok;
      ok = HDR_VEC[v][0];
      doReset();
      pushWord({16'h0, HDR_VEC[v][8:1], HDR_VEC[v][16:9]}, 1'b0);
      check(hdrGood == ok && hdrError == !ok, ok ? "R1 header accept" : "R2 header reject",
            {hdrGood, hdrError}, {ok, !ok});
      if (!ok) begin
        regWrValid = 1; regWrData = wordOf(1, 0);
        repeat (3) @(negedge clk);
        regWrValid = 0;
        check(!regWrReady && !winValid && winAvail == 0, "R2 stream closed",
              {regWrReady, winValid, 7'(winAvail)}, 0);
      end
    end

    // R3: back-pressure with nothing consumed
    doReset();
    begin
      int accepted = 0;
      regWrValid = 1; regWrData = wordOf(0, 0); regWrLast = 0;
      for (int c = 0; c < 40; c++) begin
        if (regWrReady) begin
          @(negedge clk);
          accepted++;
          regWrData = wordOf(accepted, 0);
        end else @(negedge clk);
      end
      regWrValid = 0;
      check(accepted == 18, "R3 words held", accepted, 18);
      check(!regWrReady, "R3 ready low when full", 32'(regWrReady), 0);
      check(winData == expWin(16, 576), "R3 no loss, R4 first window",
            32'(winData), 32'(expWin(16, 576)));
    end

    // R4 R5 R7 R10: little-endian stream, register path
    doReset();
    for (int i = 0; i < 10; i++) pushWord(wordOf(i, 0), i == 9);
    repeat (2) @(negedge clk);
    check(!regWrReady, "R10 closed after last", 32'(regWrReady), 0);
    pos = 16;
    runConsume(320, "R5 window after consume (LE)");

    // R6 R8: big-endian stream with byte alignment
    doReset();
    cfgBigEndian = 1;
    for (int i = 0; i < 6; i++) pushWord(wordOf(i, 1), i == 5);
    pos = 16;
    while (!winValid) @(negedge clk);
    check(winData == expWin(pos, 192), "R6 big-endian first window",
          32'(winData), 32'(expWin(pos, 192)));
    consumeN(5);
    alignReq = 1; @(negedge clk); alignReq = 0;
    pos = (pos + 7) & ~7;
    check(winData == expWin(pos, 192), "R8 align to byte", 32'(winData), 32'(expWin(pos, 192)));
    alignReq = 1; @(negedge clk); alignReq = 0;
    check(winData == expWin(pos, 192), "R8 align when aligned", 32'(winData),
          32'(expWin(pos, 192)));
    consumeN(3);
    alignReq = 1; consumeEn = 1; consumeBits = 5'd4;
    @(negedge clk);
    alignReq = 0; consumeEn = 0; pos += 4;
    check(winData == expWin(pos, 192), "R8 consume wins over align", 32'(winData),
          32'(expWin(pos, 192)));
    runConsume(192, "R6 window after consume (BE)");
    cfgBigEndian = 0;

    // R9: unselected path ignored, DMA path used
    doReset();
    cfgUseDma = 1;
    regWrValid = 1; regWrData = wordOf(0, 0);
    repeat (3) @(negedge clk);
    check(!regWrReady && !hdrGood && !hdrError, "R9 register path ignored",
          {regWrReady, hdrGood, hdrError}, 0);
    regWrValid = 0;
    for (int i = 0; i < 4; i++) pushWord(wordOf(i, 0), i == 3);
    check(hdrGood, "R9 DMA header accepted", 32'(hdrGood), 1);
    pos = 16;
    runConsume(128, "R9 window via DMA");

    $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end
endmodule